// File: doc/BRIEF.md
# Memory-Mapped UART and Interrupt Register Block

This block is a small peripheral register file on a 32-bit processor load/store bus. It claims one 256-byte I/O window at a fixed base address, 0x2000_0000 by default. Inside that window it provides five registers: a UART byte port, an interrupt enable mask, an interrupt status word, a configuration word and a process-identifier register. It also takes writes into a small translation-table window, and those writes clear a pending translation-fault flag. It combines the status word with the mask and drives one registered interrupt request to the processor.

The serial line logic is not part of this block. Bytes leave on a valid/ready output stream and arrive on a valid/ready input stream.
- Outgoing stream: a byte written by software is held in a single slot. `tx_valid` stays high and `tx_data` stays stable until the cycle in which the sink raises `tx_ready`.
- Incoming stream: the block holds at most one received byte. `rx_ready` is high only while no unread byte is held, so the source must hold back while the slot is full.
- Bus port: it has no back-pressure. A request is taken in any cycle where `req_valid` is high. A read inside the window returns its data one cycle later with `rsp_valid`, and that response cannot be stalled.

A free-running counter supplies a slow periodic interrupt source. One bit of the counter is shown as a complementary pair of status flags, so software can enable an interrupt on either phase of that bit.

Top module: `periph_regs`

## Requirements
- R1: After reset the mask, the stored status flags, the process identifier and the interrupt request are zero. `tx_valid` is low and `rx_ready` is high. A status read then shows only the transmit-free flag (bit 1) and the counter-phase flags.
- R2: A read request whose address is inside the window gives `rsp_valid` high with `rsp_data` one cycle later. No response is produced in any other cycle.
- R3: Outgoing byte path (register offset 0x00):
  - A write to offset 0x00 while the transmit slot is empty loads bits 7:0 of the write data into the slot.
  - `tx_valid` then stays high with `tx_data` stable until a cycle with `tx_ready` high.
  - A write made while the slot is full is dropped.
  - Status bit 1 reads 1 exactly when the slot is empty.
- R4: Incoming byte path (register offset 0x00):
  - A byte offered while `rx_ready` is high is stored and sets status bit 0. `rx_ready` then drops until the byte is read.
  - A read of offset 0x00 returns the last stored byte in bits 7:0, with zeros above, and clears status bit 0.
  - If a byte arrives in the same cycle as that read, the flag stays set.
- R5: The mask register at offset 0x10 is readable and writable. It keeps write-data bits 9:0 and reads back zero in bits 31:10.
- R6: The status register is at offset 0x20.
  - Bit layout: bit 0 is receive-available, bit 1 is transmit-free, bit 2 is the inverse of the counter tap, bit 3 is the counter tap, and bit 9 is the translation fault. All other bits read zero.
  - A write to offset 0x20 loads bits 0 and 9 from the write data. The other status bits are not affected by the write.
- R7: The counter is CNT_W bits wide (32 by default). It is zero while reset is held and advances by one on every clock edge after reset. The tap is counter bit CNT_BIT (18 by default).
- R8: A pulse on `mmu_miss` sets status bit 9. Any write to offsets 0xA0 up to 0xA0 + 8*TLB_ENTRIES - 1 clears bit 9. A miss in the same cycle as such a write leaves the bit set.
- R9: Writes to the configuration offset 0x70 change nothing, and reads of 0x70 return zero. Offset 0x80 holds a PID_W-bit process identifier. It is written from the low write-data bits, read back zero-extended, and driven on `process_id`.
- R10: `irq` is a register. It is high in the cycle after a cycle in which status AND mask is nonzero, and low otherwise.
- R11: Inside the window, reads of unmapped offsets return zero and writes to them change nothing. Requests outside the window are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read inside the window) |
| rsp_data | output | 32 | Read data |
| tx_valid | output | 1 | Outgoing byte available |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| rx_valid | input | 1 | Source offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive slot empty, byte can be taken |
| mmu_miss | input | 1 | Translation-miss pulse |
| process_id | output | PID_W | Current process identifier |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Most faulty internal state shows up at the ports within one or two cycles. A stuck or mis-prioritised flag changes the next status read and, through the mask, changes `irq` one edge later. A transmit slot that fails to hold or to drop shows at once on `tx_valid` and `tx_data`, and a receive slot that never empties keeps `rx_ready` low. The counter tap is predicted from the bench's own count of clock edges since reset, so an off-by-one in the counter or a wrong tap bit disagrees with the very first status read that falls near a phase change.

// File: rtl/periph_regs_pkg.sv
package periph_regs_pkg;

  localparam int BUS_W  = 32;
  localparam int OFF_W  = 8;
  localparam int UART_W = 8;
  localparam int STAT_W = 10;

  // status bit positions (software-visible, fixed)
  localparam int ST_RX    = 0;
  localparam int ST_TX    = 1;
  localparam int ST_CNT_N = 2;
  localparam int ST_CNT   = 3;
  localparam int ST_MMU   = 9;

  // register offsets within the window
  localparam logic [OFF_W-1:0] OFF_UART = 8'h00;
  localparam logic [OFF_W-1:0] OFF_MASK = 8'h10;
  localparam logic [OFF_W-1:0] OFF_STAT = 8'h20;
  localparam logic [OFF_W-1:0] OFF_CFG  = 8'h70;
  localparam logic [OFF_W-1:0] OFF_PID  = 8'h80;
  localparam logic [OFF_W-1:0] OFF_TLB  = 8'hA0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_UART,
    SEL_MASK,
    SEL_STAT,
    SEL_CFG,
    SEL_PID,
    SEL_TLB
  } reg_sel_e;

endpackage

// File: rtl/periph_addr_dec.sv
module periph_addr_dec
  import periph_regs_pkg::*;
#(
  parameter logic [BUS_W-1:0] BASE        = 32'h2000_0000,
  parameter int               TLB_ENTRIES = 4
) (
  input  logic [BUS_W-1:0] addr,
  output logic             in_region,
  output reg_sel_e         sel
);
  localparam int TLB_LO = int'(OFF_TLB);
  localparam int TLB_HI = TLB_LO + TLB_ENTRIES * 8;

  logic [OFF_W-1:0] off;
  assign off = addr[OFF_W-1:0];

  always_comb begin
    in_region = (addr[BUS_W-1:OFF_W] == BASE[BUS_W-1:OFF_W]);
    sel = SEL_NONE;
    if (off == OFF_UART)      sel = SEL_UART;
    else if (off == OFF_MASK) sel = SEL_MASK;
    else if (off == OFF_STAT) sel = SEL_STAT;
    else if (off == OFF_CFG)  sel = SEL_CFG;
    else if (off == OFF_PID)  sel = SEL_PID;
    else if (int'(off) >= TLB_LO && int'(off) < TLB_HI) sel = SEL_TLB;
  end
endmodule

// File: rtl/periph_uart_port.sv
module periph_uart_port
  import periph_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [UART_W-1:0] wbyte,
  input  logic              stat_wr,
  input  logic              stat_rx_bit,
  output logic              tx_valid,
  output logic [UART_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [UART_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_avail,
  output logic              tx_free,
  output logic [UART_W-1:0] rx_byte
);
  logic              tx_pend;
  logic [UART_W-1:0] tx_q;
  logic              rx_flag;
  logic [UART_W-1:0] rx_q;
  logic              rx_take;

  assign rx_take = rx_valid && !rx_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
      tx_q    <= '0;
    end else if (tx_pend) begin
      if (tx_ready) tx_pend <= 1'b0;
    end else if (data_wr) begin
      tx_pend <= 1'b1;
      tx_q    <= wbyte;
    end
  end

  // arrival beats software write, software write beats read-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flag <= 1'b0;
      rx_q    <= '0;
    end else if (rx_take) begin
      rx_flag <= 1'b1;
      rx_q    <= rx_data;
    end else if (stat_wr) begin
      rx_flag <= stat_rx_bit;
    end else if (data_rd) begin
      rx_flag <= 1'b0;
    end
  end

  assign tx_valid = tx_pend;
  assign tx_data  = tx_q;
  assign tx_free  = !tx_pend;
  assign rx_ready = !rx_flag;
  assign rx_avail = rx_flag;
  assign rx_byte  = rx_q;
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
  import periph_regs_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int CNT_BIT = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              stat_wr,
  input  logic              tlb_wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              mmu_miss,
  input  logic              rx_avail,
  input  logic              tx_free,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [CNT_W-1:0]  cnt;
  logic              mmu_flag;
  logic [STAT_W-1:0] mask_q;
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata[STAT_W-1:0];
  end

  // miss beats window write, window write beats software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mmu_flag <= 1'b0;
    else if (mmu_miss) mmu_flag <= 1'b1;
    else if (tlb_wr)   mmu_flag <= 1'b0;
    else if (stat_wr)  mmu_flag <= wdata[ST_MMU];
  end

  always_comb begin
    status           = '0;
    status[ST_RX]    = rx_avail;
    status[ST_TX]    = tx_free;
    status[ST_CNT_N] = ~cnt[CNT_BIT];
    status[ST_CNT]   = cnt[CNT_BIT];
    status[ST_MMU]   = mmu_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & mask_q);
  end

  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/periph_regs.sv
module periph_regs
  import periph_regs_pkg::*;
#(
  parameter logic [31:0] BASE        = 32'h2000_0000,
  parameter int          CNT_W       = 32,
  parameter int          CNT_BIT     = 18,
  parameter int          TLB_ENTRIES = 4,
  parameter int          PID_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  input  logic             mmu_miss,
  output logic [PID_W-1:0] process_id,
  output logic             irq
);
  logic              in_region;
  reg_sel_e          sel;
  logic              wr, rd;
  logic              rx_avail, tx_free;
  logic [UART_W-1:0] rx_byte;
  logic [STAT_W-1:0] status, mask;
  logic [PID_W-1:0]  pid_q;
  logic [BUS_W-1:0]  rd_val;
  logic              rsp_v_q;
  logic [BUS_W-1:0]  rsp_d_q;

  periph_addr_dec #(.BASE(BASE), .TLB_ENTRIES(TLB_ENTRIES)) u_dec (
    .addr(req_addr), .in_region(in_region), .sel(sel)
  );

  assign wr = req_valid && req_write && in_region;
  assign rd = req_valid && !req_write && in_region;

  periph_uart_port u_uart (
    .clk(clk), .rst_n(rst_n),
    .data_wr(wr && sel == SEL_UART),
    .data_rd(rd && sel == SEL_UART),
    .wbyte(req_wdata[UART_W-1:0]),
    .stat_wr(wr && sel == SEL_STAT),
    .stat_rx_bit(req_wdata[ST_RX]),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_avail(rx_avail), .tx_free(tx_free), .rx_byte(rx_byte)
  );

  periph_irq_ctrl #(.CNT_W(CNT_W), .CNT_BIT(CNT_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_wr(wr && sel == SEL_MASK),
    .stat_wr(wr && sel == SEL_STAT),
    .tlb_wr(wr && sel == SEL_TLB),
    .wdata(req_wdata),
    .mmu_miss(mmu_miss),
    .rx_avail(rx_avail), .tx_free(tx_free),
    .status(status), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pid_q <= '0;
    else if (wr && sel == SEL_PID) pid_q <= req_wdata[PID_W-1:0];
  end
  assign process_id = pid_q;

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_UART: rd_val[UART_W-1:0] = rx_byte;
      SEL_MASK: rd_val[STAT_W-1:0] = mask;
      SEL_STAT: rd_val[STAT_W-1:0] = status;
      SEL_PID:  rd_val[PID_W-1:0]  = pid_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= rd;
      rsp_d_q <= rd ? rd_val : '0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
endmodule

// File: rtl/periph_regs_chk.sv
module periph_regs_chk
  import periph_regs_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h2000_0000,
  parameter int          PID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [31:0]      req_addr,
  input logic             rsp_valid,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [PID_W-1:0] process_id
);
  logic rd_hit, pid_wr;
  assign rd_hit = req_valid && !req_write && (req_addr[31:OFF_W] == BASE[31:OFF_W]);
  assign pid_wr = req_valid && req_write && (req_addr == {BASE[31:OFF_W], OFF_PID});

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rsp_valid);

  p_rsp_only_for_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_hit));

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tx_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  p_rx_slot_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  p_pid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pid_wr |=> $stable(process_id));
endmodule

bind periph_regs periph_regs_chk #(.BASE(BASE), .PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .process_id(process_id)
);

// File: tb/test_periph_regs.sv
module test_periph_regs;
  localparam int          TAP  = 4;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        mmu_miss = 1'b0;
  logic [7:0]  process_id;
  logic        irq;

  always #4 clk = ~clk;

  periph_regs #(.BASE(BASE), .CNT_BIT(TAP), .PID_W(8)) i_periph_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .mmu_miss(mmu_miss), .process_id(process_id),
    .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] ncyc;

  always @(posedge clk) begin
    if (!rst_n) ncyc <= '0;
    else        ncyc <= ncyc + 1;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(0, "R2/R11 unexpected response", rsp_data, 32'h0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(rsp_data == it.exp, it.tag, rsp_data, it.exp);
      end
    end
  end

  task automatic bus_wr(logic [31:0] off, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = BASE + off; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(logic [31:0] off, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = BASE + off;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  // status read: counter-phase bits predicted from edges since reset
  task automatic rd_stat(logic [31:0] other, string tag);
    item_t it;
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = BASE + 32'h20;
    e = other;
    e[2] = ~ncyc[TAP];
    e[3] = ncyc[TAP];
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(tx_valid == 0, "R1 tx_valid", 32'(tx_valid), 0);
    chk(rx_ready == 1, "R1 rx_ready", 32'(rx_ready), 1);
    chk(process_id == 0, "R1 process_id", 32'(process_id), 0);
    bus_rd(32'h10, 32'h0, "R1 mask after reset");
    rd_stat(32'h002, "R1 status after reset");

    // R5 mask width, R10 registered irq
    bus_wr(32'h10, 32'hFFFF_FFFF);
    chk(irq == 0, "R10 irq one cycle late", 32'(irq), 0);
    @(negedge clk);
    chk(irq == 1, "R10 irq from tx_free", 32'(irq), 1);
    bus_rd(32'h10, 32'h0000_03FF, "R5 mask readback");
    bus_wr(32'h10, 32'h0);
    @(negedge clk);
    chk(irq == 0, "R10 irq masked off", 32'(irq), 0);

    // R3 outgoing path with back-pressure
    bus_wr(32'h00, 32'h1234_56A5);
    chk(tx_valid == 1, "R3 tx_valid", 32'(tx_valid), 1);
    chk(tx_data == 8'hA5, "R3 tx_data low byte", 32'(tx_data), 32'hA5);
    rd_stat(32'h000, "R3 status tx busy");
    bus_wr(32'h00, 32'h0000_005A);
    chk(tx_data == 8'hA5, "R3 write while full dropped", 32'(tx_data), 32'hA5);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk(tx_valid == 0, "R3 released after handshake", 32'(tx_valid), 0);
    rd_stat(32'h002, "R3 status tx free again");

    // R4 incoming path
    @(negedge clk); rx_valid = 1; rx_data = 8'h3C;
    @(negedge clk); rx_valid = 0;
    chk(rx_ready == 0, "R4 rx_ready drops", 32'(rx_ready), 0);
    rd_stat(32'h003, "R4 status rx available");
    @(negedge clk); rx_valid = 1; rx_data = 8'h77;
    @(negedge clk); rx_valid = 0;
    bus_rd(32'h00, 32'h0000_003C, "R4 read byte, offer while full ignored");
    rd_stat(32'h002, "R4 read clears bit0");
    chk(rx_ready == 1, "R4 rx_ready back", 32'(rx_ready), 1);
    bus_rd(32'h00, 32'h0000_003C, "R4 last byte retained");

    // R6 status write, R10 irq through bit0
    bus_wr(32'h20, 32'hFFFF_FFFF);
    rd_stat(32'h203, "R6 write sets bits 0 and 9 only");
    bus_wr(32'h20, 32'h0);
    rd_stat(32'h002, "R6 write clears bits 0 and 9");
    bus_wr(32'h10, 32'h001);
    bus_wr(32'h20, 32'h001);
    @(negedge clk);
    chk(irq == 1, "R10 irq from bit0", 32'(irq), 1);
    bus_wr(32'h00, 32'h0);  // read-clear is via read; use status write
    bus_wr(32'h20, 32'h0);
    bus_wr(32'h10, 32'h0);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;

    // R8 translation fault flag
    @(negedge clk); mmu_miss = 1;
    @(negedge clk); mmu_miss = 0;
    rd_stat(32'h202, "R8 miss sets bit9");
    bus_wr(32'hC0, 32'h1);
    rd_stat(32'h202, "R8 write past window keeps bit9");
    bus_wr(32'hBC, 32'h1);
    rd_stat(32'h002, "R8 last window word clears bit9");
    @(negedge clk);
    mmu_miss = 1; req_valid = 1; req_write = 1; req_addr = BASE + 32'hA4;
    @(negedge clk);
    mmu_miss = 0; req_valid = 0; req_write = 0;
    rd_stat(32'h202, "R8 miss beats window write");
    bus_wr(32'hA0, 32'h0);
    rd_stat(32'h002, "R8 first window word clears bit9");

    // R9 config and process id
    bus_wr(32'h70, 32'hFFFF_FFFF);
    bus_rd(32'h70, 32'h0, "R9 config reads zero");
    bus_rd(32'h10, 32'h0, "R9 config write left mask");
    bus_wr(32'h80, 32'h0000_01A5);
    chk(process_id == 8'hA5, "R9 process_id port", 32'(process_id), 32'hA5);
    bus_rd(32'h80, 32'h0000_00A5, "R9 process_id readback");

    // R11 unmapped and outside window
    bus_wr(32'h44, 32'hDEAD_BEEF);
    bus_rd(32'h44, 32'h0, "R11 unmapped reads zero");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 32'h3000_0010; req_wdata = 32'h3FF;
    @(negedge clk);
    req_write = 0; req_addr = 32'h3000_0020;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    bus_rd(32'h10, 32'h0, "R11 outside write ignored");

    // R7 counter tap over more than one full period
    for (int i = 0; i < 40; i++) rd_stat(32'h002, "R7 counter tap phase");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 all reads answered", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule